// File: doc/BRIEF.md
# Motor Interval Timer with Latched Output Shutdown

This block is a down-counting interval timer for motor control. It drives a bank of PWM-style channel outputs. The counter reloads from a programmable value each time it passes zero, and every pass raises a one-cycle interrupt pulse. Each channel has its own compare value. A channel goes high when the counter equals its compare value and goes low again on the next underflow. Each channel also has its own output enable.

A protection path can take every channel off the pads at once. Either of two triggers sets a latched stop state:

- a selectable edge on an asynchronous shutdown pin, which first passes through a synchronizer;
- a one-cycle watchdog event.

While the stop state is set, every pad enable is low, which means the pads are in high impedance. The interval interrupt keeps running, so software can disable the drive stage for good and still use the block as a periodic tick. Only a reset or an explicit clear strobe releases the stop state.

Top module: `mtr_tmr`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `irq` is 0, every `pwm_o` bit is 0, the stop state is clear, and `pwm_oe` equals `out_en`.
- R2: With `run` high and reload value N held constant, `irq` is high for the (N+1)-th cycle after the first edge that samples `run` high, and then once every N+1 cycles. For N above 0, each such pulse lasts exactly one cycle.
- R3: While `run` is low, `irq` stays 0, every `pwm_o` bit is 0, and the counter keeps loading the reload value.
- R4: With reload N and a channel compare value C, the channel is high for exactly C cycles of every N+1 cycle period when 1 ≤ C ≤ N. It stays low when C = 0 or C > N.
- R5: A channel whose `out_en` bit is 0 has its `pwm_oe` bit at 0 and its `pwm_o` bit at 0. The enabled channels are not affected.
- R6: `edge_sel` = 0 makes a 0→1 transition of `stop_pin` the valid shutdown edge, and `edge_sel` = 1 makes a 1→0 transition the valid edge. A transition in the other direction has no effect.
- R7: A valid pin edge sets the stop state only when `pin_stop_en` and `run` are both high.
- R8: A `wdt_evt` pulse sets the stop state whenever `wdt_stop_en` is high, whatever the value of `run`. With `wdt_stop_en` low, the pulse has no effect.
- R9: While the stop state is set, every `pwm_oe` bit and every `pwm_o` bit is 0. The state holds whatever `stop_pin` does afterwards, until a cycle with `stop_clr` high or a reset.
- R10: The interval interrupt keeps its N+1 cycle period while the stop state is set.
- R11: A pin transition sets the stop state at the third rising clock edge after it is applied. A watchdog pulse sets it at the first edge.
- R12: When a trigger and `stop_clr` are both present at the same edge, the trigger wins and the stop state is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Counter runs while high; while low the counter loads the reload value |
| edge_sel | input | 1 | Valid shutdown edge: 0 rising, 1 falling |
| pin_stop_en | input | 1 | Allows the shutdown pin to set the stop state |
| wdt_stop_en | input | 1 | Allows the watchdog event to set the stop state |
| stop_clr | input | 1 | Strobe that clears the latched stop state |
| reload_val | input | CNT_W (10) | Counter reload value; period is reload_val+1 cycles |
| cmp_val | input | N_OUT*CNT_W (60) | Channel compare values, channel i at bits [i*CNT_W +: CNT_W] |
| out_en | input | N_OUT (6) | Output enable for each channel |
| stop_pin | input | 1 | Asynchronous external shutdown pin |
| wdt_evt | input | 1 | Synchronous one-cycle watchdog event |
| irq | output | 1 | Interval interrupt pulse on underflow |
| pwm_o | output | N_OUT (6) | Channel output data |
| pwm_oe | output | N_OUT (6) | Pad enables; 0 means high impedance |

## Verification
The hardest situation to reach from the ports is a wrong-direction pin transition that arrives while the stop state is still clear. The check must show that this transition leaves the pads enabled, and that the later correct-direction transition then lands exactly three edges after it is applied. The bench first toggles the pin in the ignored direction and confirms the enables stay high. It then applies the valid edge and samples the enables in the second and third cycles afterwards. Next it moves the pin back and forth while the stop state is set, and it measures the interrupt period during that time. A watchdog pulse is made to coincide with a clear strobe so that the priority between set and clear is observed.

// File: rtl/mtr_tmr_pkg.sv
package mtr_tmr_pkg;

   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } stop_edge_e;

   localparam int unsigned MIN_CNT_W   = 2;
   localparam int unsigned MAX_CNT_W   = 16;
   localparam int unsigned MAX_N_OUT   = 16;
   localparam int unsigned MIN_SYNC    = 2;
   localparam int unsigned MAX_SYNC    = 4;

   function automatic logic edge_hit(input stop_edge_e sel, input logic now_lvl, input logic old_lvl);
      logic rise;
      logic fall;
      rise = now_lvl & ~old_lvl;
      fall = ~now_lvl & old_lvl;
      return (sel == EDGE_FALL) ? fall : rise;
   endfunction

endpackage

// File: rtl/mtr_tmr_cnt.sv
module mtr_tmr_cnt #(
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] cnt_o,
   output logic             uflow_o,
   output logic             irq_o
);
   localparam logic [CNT_W-1:0] ZERO = '0;
   localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] cnt_q;
   logic             irq_q;
   logic             uflow;

   assign uflow = run && (cnt_q == ZERO);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= ZERO;
         irq_q <= 1'b0;
      end else begin
         irq_q <= uflow;
         if (!run || uflow) begin
            cnt_q <= reload;
         end else begin
            cnt_q <= cnt_q - ONE;
         end
      end
   end

   assign cnt_o   = cnt_q;
   assign uflow_o = uflow;
   assign irq_o   = irq_q;
endmodule

// File: rtl/mtr_tmr_chan.sv
module mtr_tmr_chan #(
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] cnt,
   input  logic             uflow,
   input  logic [CNT_W-1:0] cmp,
   output logic             lvl_o
);
   logic lvl_q;
   logic hit;

   assign hit = (cnt == cmp);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl_q <= 1'b0;
      end else if (!run || uflow) begin
         lvl_q <= 1'b0;
      end else if (hit) begin
         lvl_q <= 1'b1;
      end
   end

   assign lvl_o = lvl_q;
endmodule

// File: rtl/mtr_tmr_sdn.sv
module mtr_tmr_sdn
   import mtr_tmr_pkg::*;
#(
   parameter int unsigned SYNC_DEPTH = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic pin,
   input  logic edge_sel,
   input  logic pin_en,
   input  logic wdt_evt,
   input  logic wdt_en,
   input  logic clr,
   output logic stop_o
);
   logic [SYNC_DEPTH-1:0] sync_q;
   logic                  last_q;
   logic                  stop_q;
   logic                  pin_trig;
   logic                  wdt_trig;
   stop_edge_e            sel;

   assign sel = stop_edge_e'(edge_sel);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_DEPTH-2:0], pin};
         last_q <= sync_q[SYNC_DEPTH-1];
      end
   end

   assign pin_trig = pin_en && run && edge_hit(sel, sync_q[SYNC_DEPTH-1], last_q);
   assign wdt_trig = wdt_en && wdt_evt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stop_q <= 1'b0;
      end else if (pin_trig || wdt_trig) begin
         stop_q <= 1'b1;
      end else if (clr) begin
         stop_q <= 1'b0;
      end
   end

   assign stop_o = stop_q;
endmodule

// File: rtl/mtr_tmr.sv
module mtr_tmr
   import mtr_tmr_pkg::*;
#(
   parameter int unsigned CNT_W      = 10,
   parameter int unsigned N_OUT      = 6,
   parameter int unsigned SYNC_DEPTH = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   run,
   input  logic                   edge_sel,
   input  logic                   pin_stop_en,
   input  logic                   wdt_stop_en,
   input  logic                   stop_clr,
   input  logic [CNT_W-1:0]       reload_val,
   input  logic [N_OUT*CNT_W-1:0] cmp_val,
   input  logic [N_OUT-1:0]       out_en,
   input  logic                   stop_pin,
   input  logic                   wdt_evt,
   output logic                   irq,
   output logic [N_OUT-1:0]       pwm_o,
   output logic [N_OUT-1:0]       pwm_oe
);
   localparam int unsigned CMP_BITS = N_OUT * CNT_W;

   if (CNT_W < MIN_CNT_W || CNT_W > MAX_CNT_W) begin : g_bad_cnt_w
      $error("mtr_tmr: CNT_W out of range");
   end
   if (N_OUT < 1 || N_OUT > MAX_N_OUT) begin : g_bad_n_out
      $error("mtr_tmr: N_OUT out of range");
   end
   if (SYNC_DEPTH < MIN_SYNC || SYNC_DEPTH > MAX_SYNC) begin : g_bad_sync
      $error("mtr_tmr: SYNC_DEPTH out of range");
   end
   if (CMP_BITS != $bits(cmp_val)) begin : g_bad_cmp
      $error("mtr_tmr: compare bus width mismatch");
   end

   logic [CNT_W-1:0] cnt;
   logic             uflow;
   logic [N_OUT-1:0] lvl;
   logic             stop_q;

   mtr_tmr_cnt #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .reload  (reload_val),
      .cnt_o   (cnt),
      .uflow_o (uflow),
      .irq_o   (irq)
   );

   for (genvar ch = 0; ch < N_OUT; ch++) begin : g_chan
      mtr_tmr_chan #(
         .CNT_W (CNT_W)
      ) u_chan (
         .clk   (clk),
         .rst_n (rst_n),
         .run   (run),
         .cnt   (cnt),
         .uflow (uflow),
         .cmp   (cmp_val[ch*CNT_W +: CNT_W]),
         .lvl_o (lvl[ch])
      );
   end

   mtr_tmr_sdn #(
      .SYNC_DEPTH (SYNC_DEPTH)
   ) u_sdn (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .pin      (stop_pin),
      .edge_sel (edge_sel),
      .pin_en   (pin_stop_en),
      .wdt_evt  (wdt_evt),
      .wdt_en   (wdt_stop_en),
      .clr      (stop_clr),
      .stop_o   (stop_q)
   );

   assign pwm_oe = out_en & {N_OUT{~stop_q}};
   assign pwm_o  = lvl & pwm_oe;
endmodule

// File: rtl/mtr_tmr_chk.sv
module mtr_tmr_chk #(
   parameter int unsigned N_OUT = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic [N_OUT-1:0] out_en,
   input logic             wdt_evt,
   input logic             wdt_stop_en,
   input logic             stop_clr,
   input logic             irq,
   input logic [N_OUT-1:0] pwm_o,
   input logic [N_OUT-1:0] pwm_oe,
   input logic             stop_q
);
   AST_IRQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(run)); // R2
   AST_IDLE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !irq); // R3
   AST_OE_WITHIN_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_oe & ~out_en) == '0); // R5
   AST_DATA_WITHIN_OE: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_o & ~pwm_oe) == '0); // R9
   AST_WDT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (wdt_stop_en && wdt_evt) |=> (pwm_oe == '0)); // R8
   AST_STOP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_q && !stop_clr) |=> (pwm_oe == '0)); // R9
   AST_TRIG_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_clr && wdt_stop_en && wdt_evt) |=> stop_q); // R12
endmodule

bind mtr_tmr mtr_tmr_chk #(
   .N_OUT (N_OUT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .run         (run),
   .out_en      (out_en),
   .wdt_evt     (wdt_evt),
   .wdt_stop_en (wdt_stop_en),
   .stop_clr    (stop_clr),
   .irq         (irq),
   .pwm_o       (pwm_o),
   .pwm_oe      (pwm_oe),
   .stop_q      (stop_q)
);

// File: tb/test_mtr_tmr.sv
module test_mtr_tmr;
   localparam int CW = 10;
   localparam int NO = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          run = 1'b0;
   logic          edge_sel = 1'b0;
   logic          pin_stop_en = 1'b0;
   logic          wdt_stop_en = 1'b0;
   logic          stop_clr = 1'b0;
   logic [CW-1:0] reload_val = '0;
   logic [NO*CW-1:0] cmp_val = '0;
   logic [NO-1:0] out_en = '1;
   logic          stop_pin = 1'b0;
   logic          wdt_evt = 1'b0;
   logic          irq;
   logic [NO-1:0] pwm_o;
   logic [NO-1:0] pwm_oe;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   mtr_tmr i_mtr_tmr (
      .clk (clk), .rst_n (rst_n), .run (run), .edge_sel (edge_sel),
      .pin_stop_en (pin_stop_en), .wdt_stop_en (wdt_stop_en), .stop_clr (stop_clr),
      .reload_val (reload_val), .cmp_val (cmp_val), .out_en (out_en),
      .stop_pin (stop_pin), .wdt_evt (wdt_evt),
      .irq (irq), .pwm_o (pwm_o), .pwm_oe (pwm_oe)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wait_irq(output int k);
      k = 0;
      do begin
         @(negedge clk);
         k++;
      end while (!irq && k < 3000);
   endtask

   // R2 and R3: latency, period, pulse width, idle behaviour
   task automatic meas_interval(input int r);
      int k;
      int hi;
      run = 1'b0;
      reload_val = CW'(r);
      repeat (3) @(negedge clk);
      run = 1'b1;
      wait_irq(k);
      chk(k == r + 1, "R2", "first irq latency", k, r + 1);
      k = 0;
      do begin
         @(negedge clk);
         k++;
         if (k == 1 && r > 0) chk(!irq, "R2", "irq pulse width", irq, 0);
      end while (!irq && k < 3000);
      chk(k == r + 1, "R2", "irq period", k, r + 1);
      run = 1'b0;
      @(negedge clk);
      hi = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (irq || pwm_o != '0) hi++;
      end
      chk(hi == 0, "R3", "activity while idle", hi, 0);
   endtask

   // R4 and R5: per-channel high time over one period
   task automatic meas_duty(input int r, input int cbase, input logic [NO-1:0] en);
      int hi [NO];
      int k;
      int bad_oe;
      out_en = en;
      run = 1'b0;
      reload_val = CW'(r);
      for (int i = 0; i < NO; i++) cmp_val[i*CW +: CW] = CW'(cbase + i);
      repeat (3) @(negedge clk);
      run = 1'b1;
      wait_irq(k);
      for (int i = 0; i < NO; i++) hi[i] = 0;
      bad_oe = 0;
      for (int t = 0; t <= r; t++) begin
         @(negedge clk);
         for (int i = 0; i < NO; i++) if (pwm_o[i]) hi[i]++;
         if (pwm_oe != en) bad_oe++;
      end
      for (int i = 0; i < NO; i++) begin
         int c;
         int e;
         c = cbase + i;
         e = (c >= 1 && c <= r) ? c : 0;
         if (!en[i]) e = 0;
         chk(hi[i] == e, en[i] ? "R4" : "R5", "channel high cycles", hi[i], e);
      end
      chk(bad_oe == 0, "R5", "pad enables follow out_en", bad_oe, 0);
      run = 1'b0;
      out_en = '1;
   endtask

   task automatic expect_oe(input logic [NO-1:0] e, input string req, input string what);
      chk(pwm_oe == e, req, what, pwm_oe, e);
   endtask

   task automatic clear_stop();
      stop_clr = 1'b1;
      @(negedge clk);
      stop_clr = 1'b0;
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired (all requirements) actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      int k;
      repeat (4) @(negedge clk);
      chk(irq == 1'b0, "R1", "irq in reset", irq, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(irq == 1'b0, "R1", "irq after reset", irq, 0);
      chk(pwm_o == '0, "R1", "pwm_o after reset", pwm_o, 0);
      expect_oe('1, "R1", "oe equals out_en after reset");

      for (int r = 0; r <= 20; r++) meas_interval(r);
      meas_interval(100);
      meas_interval(1023);

      for (int r = 0; r <= 9; r++) begin
         meas_duty(r, 0, '1);
         meas_duty(r, 6, '1);
      end
      meas_duty(7, 2, 6'b101010);
      meas_duty(7, 2, 6'b010101);

      // Shutdown scenarios, running with period 6
      reload_val = CW'(5);
      for (int i = 0; i < NO; i++) cmp_val[i*CW +: CW] = CW'(i + 1);
      repeat (3) @(negedge clk);
      run = 1'b1;

      // R7: pin enable low blocks the pin
      pin_stop_en = 1'b0; edge_sel = 1'b0;
      stop_pin = 1'b1;
      repeat (5) @(negedge clk);
      expect_oe('1, "R7", "pin ignored with pin_stop_en low");
      stop_pin = 1'b0;
      repeat (5) @(negedge clk);

      // R7: run low blocks the pin
      pin_stop_en = 1'b1; run = 1'b0;
      stop_pin = 1'b1;
      repeat (5) @(negedge clk);
      expect_oe('1, "R7", "pin ignored with run low");
      stop_pin = 1'b0;
      repeat (5) @(negedge clk);
      run = 1'b1;

      // R6: falling selected, rising ignored; R11 latency on falling
      edge_sel = 1'b1;
      repeat (2) @(negedge clk);
      stop_pin = 1'b1;
      repeat (5) @(negedge clk);
      expect_oe('1, "R6", "rising ignored when falling selected");
      stop_pin = 1'b0;
      repeat (2) @(negedge clk);
      expect_oe('1, "R11", "pin stop not before third edge");
      @(negedge clk);
      expect_oe('0, "R11", "pin stop at third edge");
      chk(pwm_o == '0, "R9", "data low while stopped", pwm_o, 0);

      // R9 latch against pin activity; R10 irq continues
      stop_pin = 1'b1;
      repeat (4) @(negedge clk);
      stop_pin = 1'b0;
      repeat (4) @(negedge clk);
      expect_oe('0, "R9", "stop held after pin activity");
      wait_irq(k);
      wait_irq(k);
      chk(k == 6, "R10", "irq period while stopped", k, 6);
      expect_oe('0, "R9", "stop still held");
      pin_stop_en = 1'b0;
      clear_stop();
      expect_oe('1, "R9", "clear releases stop");
      pin_stop_en = 1'b1;

      // R6: rising selected
      edge_sel = 1'b0;
      repeat (2) @(negedge clk);
      stop_pin = 1'b1;
      repeat (3) @(negedge clk);
      expect_oe('0, "R6", "rising edge stops when rising selected");
      repeat (3) @(negedge clk);
      clear_stop();
      expect_oe('1, "R9", "clear after rising stop");
      stop_pin = 1'b0;
      repeat (5) @(negedge clk);
      expect_oe('1, "R6", "falling ignored when rising selected");
      pin_stop_en = 1'b0;

      // R8 watchdog path
      wdt_stop_en = 1'b0;
      wdt_evt = 1'b1;
      @(negedge clk);
      wdt_evt = 1'b0;
      repeat (3) @(negedge clk);
      expect_oe('1, "R8", "watchdog ignored when disabled");
      wdt_stop_en = 1'b1;
      run = 1'b0;
      wdt_evt = 1'b1;
      @(negedge clk);
      wdt_evt = 1'b0;
      expect_oe('0, "R8", "watchdog stops with run low");
      chk(pwm_oe == '0, "R11", "watchdog stop after one edge", pwm_oe, 0);
      clear_stop();
      expect_oe('1, "R9", "clear after watchdog stop");

      // R12 trigger beats clear
      wdt_evt = 1'b1;
      stop_clr = 1'b1;
      @(negedge clk);
      wdt_evt = 1'b0;
      stop_clr = 1'b0;
      expect_oe('0, "R12", "trigger wins over clear");
      clear_stop();
      expect_oe('1, "R12", "later clear releases");

      // R1: reset releases a latched stop
      wdt_evt = 1'b1;
      @(negedge clk);
      wdt_evt = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      expect_oe('1, "R1", "reset clears stop");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule